// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block is a clocked state machine that opens a lock only after three dial operations arrive in the right order. Each operation is a turn direction (right or left) and a dial number from 0 to 39. The operation is presented for one cycle with a valid strobe. The unlocking code is right-13, then left-22, then right-3. Having the right numbers is not enough. Each step must match both the direction and the number, and the steps must come in sequence.

The controller has four states. They are idle, one step matched, two steps matched, and open. The open flag is a registered Moore output of the state. Once open, the lock ignores the dial until a relock request or a reset returns it to idle. When a valid operation is not the expected next step, progress is abandoned. If that wrong operation happens to be the first step of the code, it begins a new attempt at once.

Top module: `combo_lock`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters idle (`lock_state` = 0) and `lock_open` is 0 after that edge.
- R2: In idle, a valid operation with `turn_right` = 1 and `dial_num` = 13 moves the state to one-step (`lock_state` = 1).
- R3: In one-step, a valid operation with `turn_right` = 0 and `dial_num` = 22 moves the state to two-step (`lock_state` = 2).
- R4: In two-step, a valid operation with `turn_right` = 1 and `dial_num` = 3 moves the state to open (`lock_state` = 3). `lock_open` is 1 exactly when `lock_state` is 3.
- R5: In idle, one-step or two-step, any valid operation that is not the expected next step returns the state to idle, except as R6 states. Such operations include the right number with the wrong direction, and any `dial_num` above 39.
- R6: In one-step or two-step, a valid but unexpected right-13 operation moves the state to one-step instead of idle.
- R7: When `op_valid` and `relock_req` are both low, the state and `lock_open` hold, whatever `turn_right` and `dial_num` carry.
- R8: In open, valid dial operations have no effect: the state stays 3 and `lock_open` stays 1.
- R9: `relock_req` high at an edge sends the state to idle from any state. It takes precedence over a simultaneous valid operation.
- R10: The three code values entered in any other order do not open the lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| turn_right | input | 1 | Turn direction of the operation: 1 = right, 0 = left |
| dial_num | input | 6 | Dial number of the operation; valid range 0 to 39 |
| op_valid | input | 1 | One-cycle strobe qualifying `turn_right` and `dial_num` |
| relock_req | input | 1 | Request to return to idle and close the lock |
| lock_open | output | 1 | Registered open flag, high only in the open state |
| lock_state | output | 2 | Current state: 0 idle, 1 one-step, 2 two-step, 3 open |

## Verification
Every result of this block is due one clock edge after its stimulus. This holds for the state transition on a valid operation, the return to idle on relock or reset, and the update of `lock_open`. The bench drives each operation away from the edge, waits for exactly one rising edge, and samples `lock_state` and `lock_open` a nanosecond later, before the next stimulus is applied. Hold cases are checked after several edges with the strobe low. This shows that no later edge moves the state either.

// File: rtl/combo_lock_pkg.sv
// Package: shared state encoding and code definition for the combination lock.
// Assumes: the lock has exactly three code steps and four states.
package combo_lock_pkg;

    // Number of code steps; the state count is one more than this.
    localparam int NUM_STEPS = 3;

    // State encoding; the numeric value equals the count of matched steps.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ONE  = 2'd1,
        ST_TWO  = 2'd2,
        ST_OPEN = 2'd3
    } lock_st_t;

endpackage

// File: rtl/combo_lock_match.sv
// Module: combo_lock_match
// Compares one dial operation against every code step in parallel and
// raises one hit bit per step whose direction and number both agree.
// Assumes: numbers above DIAL_MAX never match any step.
module combo_lock_match #(
    parameter int                         DIAL_W    = 6,
    parameter int                         DIAL_MAX  = 39,
    parameter int                         STEPS     = 3,
    parameter logic [STEPS-1:0]           CODE_DIR  = 3'b101,
    parameter logic [STEPS*DIAL_W-1:0]    CODE_NUM  = {6'd3, 6'd22, 6'd13}
) (
    input  logic              turn_right,
    input  logic [DIAL_W-1:0] dial_num,
    output logic [STEPS-1:0]  step_hit
);

    localparam logic [DIAL_W-1:0] NUM_LIMIT = DIAL_W'(DIAL_MAX);

    logic in_range;

    // Purpose: flag dial numbers inside the legal dial range.
    always_comb begin
        in_range = (dial_num <= NUM_LIMIT);
    end

    // One comparator per code step.
    for (genvar s = 0; s < STEPS; s++) begin : g_step
        // Purpose: match direction and number of step s.
        always_comb begin
            step_hit[s] = in_range
                       && (turn_right == CODE_DIR[s])
                       && (dial_num == CODE_NUM[s*DIAL_W +: DIAL_W]);
        end
    end

endmodule

// File: rtl/combo_lock_next.sv
// Module: combo_lock_next
// Combinational next-state logic of the lock sequence.
// Assumes: step_hit[0] is the first code step; relock has top priority,
// and the state moves only on a valid operation.
module combo_lock_next
    import combo_lock_pkg::*;
(
    input  lock_st_t               cur_st,
    input  logic [NUM_STEPS-1:0]   step_hit,
    input  logic                   op_valid,
    input  logic                   relock_req,
    output lock_st_t               nxt_st
);

    lock_st_t restart_st;

    // Purpose: pick where a wrong operation lands (fresh attempt or idle).
    always_comb begin
        restart_st = step_hit[0] ? ST_ONE : ST_IDLE;
    end

    // Purpose: compute the state for the next clock edge.
    always_comb begin
        nxt_st = cur_st;
        if (relock_req) begin
            nxt_st = ST_IDLE;
        end else if (op_valid) begin
            unique case (cur_st)
                ST_IDLE: nxt_st = step_hit[0] ? ST_ONE  : ST_IDLE;
                ST_ONE:  nxt_st = step_hit[1] ? ST_TWO  : restart_st;
                ST_TWO:  nxt_st = step_hit[2] ? ST_OPEN : restart_st;
                ST_OPEN: nxt_st = ST_OPEN;
                default: nxt_st = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/combo_lock_regs.sv
// Module: combo_lock_regs
// State register and registered open flag of the lock.
// Assumes: synchronous active-low reset; the open flag is derived from the
// next state so that it changes on the same edge as the state.
module combo_lock_regs
    import combo_lock_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lock_st_t nxt_st,
    output lock_st_t cur_st,
    output logic     open_q
);

    // Purpose: hold the lock state, clearing to idle on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_st <= ST_IDLE;
        end else begin
            cur_st <= nxt_st;
        end
    end

    // Purpose: register the Moore open output alongside the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else begin
            open_q <= (nxt_st == ST_OPEN);
        end
    end

endmodule

// File: rtl/combo_lock.sv
// Module: combo_lock (top)
// Order-sensitive combination lock: three dial operations, each a direction
// and a number, must arrive in sequence to open the lock.
// Assumes: operations are one-cycle strobes already decoded and debounced.
module combo_lock
    import combo_lock_pkg::*;
#(
    parameter int                            DIAL_W   = 6,
    parameter int                            DIAL_MAX = 39,
    parameter logic [NUM_STEPS-1:0]          CODE_DIR = 3'b101,
    parameter logic [NUM_STEPS*DIAL_W-1:0]   CODE_NUM = {6'd3, 6'd22, 6'd13}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              turn_right,
    input  logic [DIAL_W-1:0] dial_num,
    input  logic              op_valid,
    input  logic              relock_req,
    output logic              lock_open,
    output logic [1:0]        lock_state
);

    logic [NUM_STEPS-1:0] step_hit;
    lock_st_t             cur_st;
    lock_st_t             nxt_st;
    logic                 open_q;

    combo_lock_match #(
        .DIAL_W   (DIAL_W),
        .DIAL_MAX (DIAL_MAX),
        .STEPS    (NUM_STEPS),
        .CODE_DIR (CODE_DIR),
        .CODE_NUM (CODE_NUM)
    ) u_match (
        .turn_right (turn_right),
        .dial_num   (dial_num),
        .step_hit   (step_hit)
    );

    combo_lock_next u_next (
        .cur_st     (cur_st),
        .step_hit   (step_hit),
        .op_valid   (op_valid),
        .relock_req (relock_req),
        .nxt_st     (nxt_st)
    );

    combo_lock_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt_st (nxt_st),
        .cur_st (cur_st),
        .open_q (open_q)
    );

    // Purpose: drive the outputs from the registered state.
    always_comb begin
        lock_open  = open_q;
        lock_state = cur_st;
    end

endmodule

// File: rtl/combo_lock_sva.sv
// Module: combo_lock_sva
// Checker for combo_lock, attached with bind. Observes ports only.
// Assumes: default code right-13, left-22, right-3; right = 1.
module combo_lock_sva #(
    parameter int DIAL_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              turn_right,
    input logic [DIAL_W-1:0] dial_num,
    input logic              op_valid,
    input logic              relock_req,
    input logic              lock_open,
    input logic [1:0]        lock_state
);

    logic live_op;
    // Purpose: a valid operation not overridden by relock.
    always_comb begin
        live_op = op_valid && !relock_req;
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (lock_state == 2'd0 && !lock_open));

    assert_first_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state == 2'd0 && live_op && turn_right && dial_num == DIAL_W'(13))
        |=> lock_state == 2'd1);

    assert_second_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state == 2'd1 && live_op && !turn_right && dial_num == DIAL_W'(22))
        |=> lock_state == 2'd2);

    assert_third_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state == 2'd2 && live_op && turn_right && dial_num == DIAL_W'(3))
        |=> lock_state == 2'd3);

    assert_open_only_d_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_open == (lock_state == 2'd3));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !relock_req) |=> ($stable(lock_state) && $stable(lock_open)));

    assert_open_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state == 2'd3 && !relock_req) |=> (lock_state == 2'd3 && lock_open));

    assert_relock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        relock_req |=> (lock_state == 2'd0 && !lock_open));

endmodule

bind combo_lock combo_lock_sva #(.DIAL_W(DIAL_W)) u_combo_lock_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .turn_right (turn_right),
    .dial_num   (dial_num),
    .op_valid   (op_valid),
    .relock_req (relock_req),
    .lock_open  (lock_open),
    .lock_state (lock_state)
);

// File: tb/combo_lock_bench.sv
`timescale 1ns/1ps
// Bench for combo_lock: a vector table walked by one loop, then directed
// tests for hold with live data and for reset while open.
module combo_lock_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       turn_right;
    logic [5:0] dial_num;
    logic       op_valid;
    logic       relock_req;
    logic       lock_open;
    logic [1:0] lock_state;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    combo_lock u_combo_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .turn_right (turn_right),
        .dial_num   (dial_num),
        .op_valid   (op_valid),
        .relock_req (relock_req),
        .lock_open  (lock_open),
        .lock_state (lock_state)
    );

    // Vector fields: [15] relock, [14] valid, [13] right, [12:7] number,
    // [6:5] expected state, [4] expected open, [3:0] requirement number.
    localparam int NV = 28;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b1, 6'd13, 2'd1, 1'b0, 4'd2},   // R2 first step
        {1'b0, 1'b1, 1'b0, 6'd22, 2'd2, 1'b0, 4'd3},   // R3 second step
        {1'b0, 1'b1, 1'b1, 6'd3,  2'd3, 1'b1, 4'd4},   // R4 opens
        {1'b0, 1'b1, 1'b1, 6'd13, 2'd3, 1'b1, 4'd8},   // R8 ignored
        {1'b0, 1'b1, 1'b0, 6'd5,  2'd3, 1'b1, 4'd8},   // R8 ignored
        {1'b1, 1'b0, 1'b0, 6'd0,  2'd0, 1'b0, 4'd9},   // R9 relock
        {1'b0, 1'b1, 1'b0, 6'd13, 2'd0, 1'b0, 4'd5},   // R5 wrong direction
        {1'b0, 1'b1, 1'b1, 6'd13, 2'd1, 1'b0, 4'd2},   // R2
        {1'b0, 1'b0, 1'b0, 6'd22, 2'd1, 1'b0, 4'd7},   // R7 strobe low
        {1'b0, 1'b1, 1'b1, 6'd22, 2'd0, 1'b0, 4'd5},   // R5 wrong dir in B
        {1'b0, 1'b1, 1'b1, 6'd13, 2'd1, 1'b0, 4'd2},   // R2
        {1'b0, 1'b1, 1'b0, 6'd22, 2'd2, 1'b0, 4'd3},   // R3
        {1'b0, 1'b1, 1'b1, 6'd13, 2'd1, 1'b0, 4'd6},   // R6 restart from C
        {1'b0, 1'b1, 1'b1, 6'd13, 2'd1, 1'b0, 4'd6},   // R6 restart from B
        {1'b0, 1'b1, 1'b0, 6'd22, 2'd2, 1'b0, 4'd3},   // R3
        {1'b0, 1'b1, 1'b0, 6'd3,  2'd0, 1'b0, 4'd5},   // R5 left-3 in C
        {1'b0, 1'b1, 1'b0, 6'd22, 2'd0, 1'b0, 4'd10},  // R10 out of order
        {1'b0, 1'b1, 1'b1, 6'd3,  2'd0, 1'b0, 4'd10},  // R10
        {1'b0, 1'b1, 1'b1, 6'd13, 2'd1, 1'b0, 4'd2},   // R2
        {1'b0, 1'b1, 1'b1, 6'd3,  2'd0, 1'b0, 4'd10},  // R10 swapped steps
        {1'b0, 1'b1, 1'b1, 6'd13, 2'd1, 1'b0, 4'd2},   // R2
        {1'b0, 1'b1, 1'b0, 6'd22, 2'd2, 1'b0, 4'd3},   // R3
        {1'b1, 1'b1, 1'b1, 6'd3,  2'd0, 1'b0, 4'd9},   // R9 relock wins
        {1'b0, 1'b1, 1'b1, 6'd13, 2'd1, 1'b0, 4'd2},   // R2
        {1'b0, 1'b1, 1'b0, 6'd22, 2'd2, 1'b0, 4'd3},   // R3
        {1'b0, 1'b1, 1'b1, 6'd43, 2'd0, 1'b0, 4'd5},   // R5 out of range
        {1'b0, 1'b1, 1'b1, 6'd13, 2'd1, 1'b0, 4'd2},   // R2
        {1'b0, 1'b1, 1'b0, 6'd62, 2'd0, 1'b0, 4'd5}    // R5 out of range
    };

    // Apply one operation, let one edge pass, sample 1 ns after it.
    task automatic apply(input logic rl, input logic v, input logic d, input logic [5:0] n);
        relock_req = rl;
        op_valid   = v;
        turn_right = d;
        dial_num   = n;
        @(posedge clk);
        #1;
        relock_req = 1'b0;
        op_valid   = 1'b0;
    endtask

    task automatic check(input int req, input logic [1:0] exp_st, input logic exp_open);
        tests++;
        if (lock_state !== exp_st) begin
            fails++;
            $display("FAIL R%0d state: actual %0d expected %0d", req, lock_state, exp_st);
        end
        tests++;
        if (lock_open !== exp_open) begin
            fails++;
            $display("FAIL R%0d open: actual %0b expected %0b", req, lock_open, exp_open);
        end
    endtask

    initial begin
        rst_n      = 1'b0;
        turn_right = 1'b0;
        dial_num   = '0;
        op_valid   = 1'b0;
        relock_req = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(1, 2'd0, 1'b0);   // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12:7]);
            check(int'(VEC[i][3:0]), VEC[i][6:5], VEC[i][4]);
        end

        // R7: strobe low with matching data present holds in C.
        apply(1'b0, 1'b1, 1'b1, 6'd13);
        apply(1'b0, 1'b1, 1'b0, 6'd22);
        turn_right = 1'b1;
        dial_num   = 6'd3;
        repeat (3) @(posedge clk);
        #1;
        check(7, 2'd2, 1'b0);

        // R1: reset while open closes the lock.
        apply(1'b0, 1'b1, 1'b1, 6'd3);
        check(4, 2'd3, 1'b1);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(1, 2'd0, 1'b0);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        done = 1'b1;
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule